// File: doc/BRIEF.md
# Upper-Memory RAM Overlay Bank Controller

This block steers the upper 12K of a 64K byte address space (pages 0xD0 to 0xFF) between a fixed ROM and a 16K overlay RAM. The overlay holds two alternative 4K banks for pages 0xD0 to 0xDF and one shared 8K block for pages 0xE0 to 0xFF. A set of sixteen soft-switch addresses in the I/O page controls it. Each access to one of them updates four flags: which 4K bank is selected, whether reads go to RAM, whether writes go to RAM, and an arming flag. Writes to RAM are enabled only after two back-to-back reads of a write-enabling switch.

For the page being accessed, the controller gives separate read and write sources. An auxiliary-set input chooses between two complete copies of the overlay RAM. Two status offsets return the bank and read-enable flags in bit 7. The memory arrays are outside the block. It only names the source each access should use.

Top module: `lc_ctrl`

## Requirements
- R1: After reset, bank 1 is selected and RAM read, RAM write and the arming flag are all clear. Every page from 0xD0 to 0xFF then reads and writes ROM, and both status offsets return 0x00.
- R2: Switch offsets 0x84–0x87 act exactly like 0x80–0x83, and offsets 0x8C–0x8F act exactly like 0x88–0x8B.
- R3: An access of either kind to a switch whose offset bits [1:0] are 00 enables RAM read, disables RAM write and clears the arming flag.
- R4: An access of either kind to a switch whose offset bits [1:0] are 10 selects ROM read, disables RAM write and clears the arming flag.
- R5: A read access to a switch whose offset bits [1:0] are 01 or 11 loads RAM write from the arming flag and then sets the arming flag. Two consecutive such reads enable writing, and a single read does not.
- R6: A write access to an odd switch (bits [1:0] 01 or 11) clears the arming flag and leaves RAM write unchanged.
- R7: Offset bits [1:0] of 01 select ROM read and 11 select RAM read. Offset bit 3 set selects bank 1 and clear selects bank 2.
- R8: Source codes are 0 for ROM, 1 for the 4K bank 1, 2 for the 4K bank 2 and 3 for the shared 8K RAM. With RAM read on, pages 0xD0–0xDF read the selected 4K bank and pages 0xE0–0xFF read the shared RAM. With RAM read off, all of these pages read ROM.
- R9: The write source follows the same page mapping when RAM write is on. When it is off, the write source is ROM (code 0), meaning the write is discarded.
- R10: The aux outputs for read and write equal the auxiliary-set input whenever the matching source is RAM, and are 0 when it is ROM.
- R11: A read access to status offset 0x11 returns 0x80 when bank 2 is selected and 0x00 otherwise. A read access to offset 0x12 returns 0x80 when RAM read is on and 0x00 otherwise. The valid output marks these reads.
- R12: Accesses outside offsets 0x80–0x8F, including status reads, leave all four flags unchanged. In particular they do not break up the two-read write-enable sequence.
- R13: Pages below 0xD0 give a map hit of 0 and source ROM (code 0) for both read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_sel | input | 1 | An I/O-page access is happening this cycle |
| sw_wr | input | 1 | The access is a write (1) or a read (0) |
| sw_off | input | 8 | Offset of the access within the I/O page |
| aux_set | input | 1 | Selects the auxiliary copy of the overlay RAM |
| page | input | 8 | Page (address bits 15:8) of the current memory access |
| map_hit | output | 1 | The page lies in the 0xD0–0xFF region |
| rd_src | output | 2 | Read source code for the page |
| rd_aux | output | 1 | The read goes to the auxiliary RAM copy |
| wr_src | output | 2 | Write source code for the page (0 means the write is dropped) |
| wr_aux | output | 1 | The write goes to the auxiliary RAM copy |
| stat_vld | output | 1 | A status offset is being read this cycle |
| stat_data | output | 8 | Status byte |

## Verification
A switch access updates the flags at the clock edge where sw_sel is high. From that edge on, the mapping outputs show the new state combinationally, with no further delay. The bench drives each access at a falling edge and removes it at the next falling edge. It then changes page and aux_set and samples the mapping shortly afterwards, so every sample falls after the single register stage. Status bytes depend combinationally on the current flags and offset, so they are sampled inside the read access, before the edge that ends it.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    SRC_ROM    = 2'd0,
    SRC_BANK1  = 2'd1,
    SRC_BANK2  = 2'd2,
    SRC_COMMON = 2'd3
  } lc_src_e;

  typedef struct packed {
    logic bank1;
    logic rd_ram;
    logic wr_ram;
    logic armed;
  } lc_state_t;

  localparam lc_state_t LC_RESET = '{bank1: 1'b1, rd_ram: 1'b0, wr_ram: 1'b0, armed: 1'b0};
endpackage

// File: rtl/lc_decode.sv
module lc_decode
  import lc_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] SW_BASE = 8'h80
) (
  input  logic             sel,
  input  logic             wr,
  input  logic [OFF_W-1:0] off,
  input  lc_state_t        cur,
  output logic             upd,
  output lc_state_t        nxt
);
  localparam int SPAN_BITS = 4;

  logic in_window;
  logic odd_sw;

  assign in_window = (off[OFF_W-1:SPAN_BITS] == SW_BASE[OFF_W-1:SPAN_BITS]);
  assign upd       = sel & in_window;
  assign odd_sw    = off[0];

  always_comb begin
    nxt        = cur;
    nxt.bank1  = off[3];
    nxt.rd_ram = (off[1:0] == 2'b00) | (off[1:0] == 2'b11);
    if (!odd_sw) begin
      nxt.wr_ram = 1'b0;
      nxt.armed  = 1'b0;
    end else if (wr) begin
      nxt.armed  = 1'b0;
    end else begin
      nxt.wr_ram = cur.armed;
      nxt.armed  = 1'b1;
    end
  end
endmodule

// File: rtl/lc_flags.sv
module lc_flags
  import lc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  lc_state_t nxt,
  output logic      rst_n_s,
  output lc_state_t st
);
  logic rst_meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st <= LC_RESET;
    end else if (en) begin
      st <= nxt;
    end
  end
endmodule

// File: rtl/lc_map.sv
module lc_map
  import lc_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              aux_set,
  input  logic [PAGE_W-1:0] page,
  input  lc_state_t         st,
  output logic              hit,
  output logic [1:0]        src   [2],
  output logic              aux   [2]
);
  localparam int NIB_LO = PAGE_W - 4;
  localparam logic [3:0] BANK_NIB = 4'hD;

  logic [3:0] nib;
  logic       in_bank;

  assign nib     = page[PAGE_W-1:NIB_LO];
  assign in_bank = (nib == BANK_NIB);
  assign hit     = (nib >= BANK_NIB);

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic ram_on;
    lc_src_e s;
    assign ram_on = (p == 0) ? st.rd_ram : st.wr_ram;
    always_comb begin
      s = SRC_ROM;
      if (hit && ram_on) begin
        if (!in_bank)      s = SRC_COMMON;
        else if (st.bank1) s = SRC_BANK1;
        else               s = SRC_BANK2;
      end
    end
    assign src[p] = s;
    assign aux[p] = aux_set & (s != SRC_ROM);
  end
endmodule

// File: rtl/lc_status.sv
module lc_status
  import lc_pkg::*;
#(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8,
  parameter logic [OFF_W-1:0] ST_BANK = 8'h11,
  parameter logic [OFF_W-1:0] ST_READ = 8'h12
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [OFF_W-1:0]  off,
  input  lc_state_t         st,
  output logic              vld,
  output logic [DATA_W-1:0] data
);
  logic flag;

  always_comb begin
    vld  = 1'b0;
    flag = 1'b0;
    if (sel && !wr) begin
      if (off == ST_BANK) begin
        vld  = 1'b1;
        flag = ~st.bank1;
      end else if (off == ST_READ) begin
        vld  = 1'b1;
        flag = st.rd_ram;
      end
    end
    data = {flag, {(DATA_W-1){1'b0}}};
  end
endmodule

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import lc_pkg::*;
#(
  parameter int OFF_W  = 8,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_sel,
  input  logic              sw_wr,
  input  logic [OFF_W-1:0]  sw_off,
  input  logic              aux_set,
  input  logic [PAGE_W-1:0] page,
  output logic              map_hit,
  output logic [1:0]        rd_src,
  output logic              rd_aux,
  output logic [1:0]        wr_src,
  output logic              wr_aux,
  output logic              stat_vld,
  output logic [DATA_W-1:0] stat_data
);
  lc_state_t st_q;
  lc_state_t st_d;
  logic      st_en;
  logic      rst_n_s;
  logic [1:0] src_w [2];
  logic       aux_w [2];

  lc_decode #(.OFF_W(OFF_W)) u_dec (
    .sel(sw_sel), .wr(sw_wr), .off(sw_off), .cur(st_q), .upd(st_en), .nxt(st_d)
  );

  lc_flags u_flg (
    .clk(clk), .rst_n(rst_n), .en(st_en), .nxt(st_d), .rst_n_s(rst_n_s), .st(st_q)
  );

  lc_map #(.PAGE_W(PAGE_W)) u_map (
    .aux_set(aux_set), .page(page), .st(st_q), .hit(map_hit), .src(src_w), .aux(aux_w)
  );

  lc_status #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_st (
    .sel(sw_sel), .wr(sw_wr), .off(sw_off), .st(st_q), .vld(stat_vld), .data(stat_data)
  );

  assign rd_src = src_w[0];
  assign rd_aux = aux_w[0];
  assign wr_src = src_w[1];
  assign wr_aux = aux_w[1];
endmodule

// File: rtl/lc_ctrl_chk.sv
module lc_ctrl_chk #(
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             sw_sel,
  input logic             sw_wr,
  input logic [OFF_W-1:0] sw_off,
  input logic             aux_set,
  input logic             map_hit,
  input logic [1:0]       wr_src,
  input logic             rd_aux,
  input logic             bank1,
  input logic             rd_ram,
  input logic             wr_ram,
  input logic             armed
);
  logic lc_acc;
  assign lc_acc = sw_sel && (sw_off[OFF_W-1:4] == 4'h8);

  p_even_clear_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lc_acc && !sw_off[0]) |=> (!wr_ram && !armed));

  p_odd_read_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lc_acc && sw_off[0] && !sw_wr) |=> (armed && wr_ram == $past(armed)));

  p_odd_write_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lc_acc && sw_off[0] && sw_wr) |=> (!armed && wr_ram == $past(wr_ram)));

  p_bank_sel_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    lc_acc |=> (bank1 == $past(sw_off[3])));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lc_acc |=> $stable({bank1, rd_ram, wr_ram, armed}));

  p_wr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (map_hit && !wr_ram) |-> (wr_src == 2'd0));

  p_aux_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_aux |-> aux_set);
endmodule

bind lc_ctrl lc_ctrl_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .sw_sel(sw_sel), .sw_wr(sw_wr), .sw_off(sw_off),
  .aux_set(aux_set), .map_hit(map_hit), .wr_src(wr_src), .rd_aux(rd_aux),
  .bank1(st_q.bank1), .rd_ram(st_q.rd_ram), .wr_ram(st_q.wr_ram), .armed(st_q.armed)
);

// File: tb/lc_ctrl_test.sv
module lc_ctrl_test;
  logic       clk;
  logic       rst_n;
  logic       sw_sel;
  logic       sw_wr;
  logic [7:0] sw_off;
  logic       aux_set;
  logic [7:0] page;
  logic       map_hit;
  logic [1:0] rd_src;
  logic       rd_aux;
  logic [1:0] wr_src;
  logic       wr_aux;
  logic       stat_vld;
  logic [7:0] stat_data;

  int checks = 0;
  int errors = 0;

  lc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sw_sel(sw_sel), .sw_wr(sw_wr), .sw_off(sw_off),
    .aux_set(aux_set), .page(page), .map_hit(map_hit), .rd_src(rd_src),
    .rd_aux(rd_aux), .wr_src(wr_src), .wr_aux(wr_aux), .stat_vld(stat_vld),
    .stat_data(stat_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [7:0] o, input logic w);
    @(negedge clk);
    sw_sel = 1'b1; sw_off = o; sw_wr = w;
    @(negedge clk);
    sw_sel = 1'b0; sw_wr = 1'b0;
  endtask

  task automatic stat(input logic [7:0] o, input int exp, input string tag);
    @(negedge clk);
    sw_sel = 1'b1; sw_off = o; sw_wr = 1'b0;
    #1;
    chk({tag, " vld"}, stat_vld, 1);
    chk(tag, stat_data, exp);
    @(negedge clk);
    sw_sel = 1'b0;
  endtask

  task automatic map(input logic [7:0] pg, input logic ax, input int e_rd, input int e_wr,
                     input string tag);
    page = pg; aux_set = ax;
    #1;
    chk({tag, " rd"}, rd_src, e_rd);
    chk({tag, " wr"}, wr_src, e_wr);
    chk({tag, " rdaux"}, rd_aux, (e_rd != 0) ? int'(ax) : 0);
    chk({tag, " wraux"}, wr_aux, (e_wr != 0) ? int'(ax) : 0);
  endtask

  task automatic t_reset;
    map(8'hD0, 1'b0, 0, 0, "R1 D0");
    map(8'hF8, 1'b0, 0, 0, "R1 F8");
    stat(8'h11, 8'h00, "R1 bank status");
    stat(8'h12, 8'h00, "R1 read status");
    map(8'h40, 1'b0, 0, 0, "R13 low page");
    chk("R13 hit", map_hit, 0);
    map(8'hCF, 1'b0, 0, 0, "R13 CF");
    chk("R13 CF hit", map_hit, 0);
  endtask

  task automatic t_even;
    acc(8'h80, 1'b0);
    map(8'hD5, 1'b0, 2, 0, "R3 R8 bank2 D5");
    map(8'hE0, 1'b0, 3, 0, "R8 common E0");
    chk("R13 hit D5", map_hit, 1);
    stat(8'h11, 8'h80, "R11 bank2");
    stat(8'h12, 8'h80, "R11 ram read");
    acc(8'h82, 1'b1);
    map(8'hD5, 1'b0, 0, 0, "R4 rom read");
    stat(8'h12, 8'h00, "R11 rom read");
    acc(8'h88, 1'b0);
    map(8'hDF, 1'b0, 1, 0, "R8 bank1 DF");
    stat(8'h11, 8'h00, "R11 bank1");
  endtask

  task automatic t_wren;
    acc(8'h8A, 1'b0);
    acc(8'h8B, 1'b0);
    map(8'hD0, 1'b0, 1, 0, "R5 single read");
    acc(8'h8B, 1'b0);
    map(8'hD0, 1'b0, 1, 1, "R5 R9 double read D0");
    map(8'hF0, 1'b0, 3, 3, "R9 common F0");
    acc(8'h8A, 1'b0);
    acc(8'h81, 1'b0);
    acc(8'h81, 1'b0);
    map(8'hD3, 1'b0, 0, 2, "R7 rom read bank2 write");
  endtask

  task automatic t_cancel;
    acc(8'h82, 1'b0);
    acc(8'h83, 1'b0);
    acc(8'h83, 1'b1);
    acc(8'h83, 1'b0);
    map(8'hD0, 1'b0, 2, 0, "R6 write breaks sequence");
    acc(8'h83, 1'b0);
    map(8'hD0, 1'b0, 2, 2, "R6 enabled after two reads");
    acc(8'h83, 1'b1);
    map(8'hD0, 1'b0, 2, 2, "R6 write keeps enable");
    acc(8'h83, 1'b0);
    map(8'hD0, 1'b0, 2, 0, "R6 disarmed then one read");
  endtask

  task automatic t_even_disarm;
    acc(8'h82, 1'b0);
    acc(8'h81, 1'b0);
    acc(8'h80, 1'b0);
    acc(8'h81, 1'b0);
    map(8'hE4, 1'b0, 0, 0, "R3 clears arming");
    acc(8'h82, 1'b0);
    acc(8'h89, 1'b0);
    acc(8'h8A, 1'b1);
    acc(8'h89, 1'b0);
    map(8'hD4, 1'b0, 0, 0, "R4 clears arming");
  endtask

  task automatic t_unrel;
    acc(8'h82, 1'b0);
    acc(8'h8B, 1'b0);
    stat(8'h11, 8'h00, "R12 status between");
    acc(8'h30, 1'b1);
    acc(8'h05, 1'b0);
    acc(8'h8B, 1'b0);
    map(8'hD8, 1'b0, 1, 1, "R12 sequence survives");
  endtask

  task automatic t_mirror;
    acc(8'h86, 1'b0);
    acc(8'h84, 1'b0);
    map(8'hD1, 1'b0, 2, 0, "R2 84 as 80");
    acc(8'h8F, 1'b0);
    acc(8'h8F, 1'b0);
    map(8'hD1, 1'b0, 1, 1, "R2 8F as 8B");
    acc(8'h8E, 1'b0);
    map(8'hD1, 1'b0, 0, 0, "R2 8E as 8A");
    acc(8'h85, 1'b0);
    acc(8'h85, 1'b0);
    map(8'hD1, 1'b0, 0, 2, "R2 85 as 81");
  endtask

  task automatic t_aux;
    acc(8'h8A, 1'b0);
    acc(8'h8B, 1'b0);
    acc(8'h8B, 1'b0);
    map(8'hD0, 1'b1, 1, 1, "R10 aux bank1");
    map(8'hFF, 1'b1, 3, 3, "R10 aux common");
    map(8'hFF, 1'b0, 3, 3, "R10 main common");
    acc(8'h8A, 1'b0);
    map(8'hD0, 1'b1, 0, 0, "R10 rom no aux");
    map(8'h20, 1'b1, 0, 0, "R13 low page aux");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sw_sel = 1'b0; sw_wr = 1'b0; sw_off = 8'h00;
    aux_set = 1'b0; page = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_even();
    t_wren();
    t_cancel();
    t_even_disarm();
    t_unrel();
    t_mirror();
    t_aux();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule